// File: doc/BRIEF.md
# Wake-Sleep Power State Controller

This block sequences the power modes of a battery-pack front end. It keeps the device in a power-down state until every supply-good input is high. It then runs in the main operating state with the regulator and monitors enabled. It drops into a low-power sleep state when software sets a sleep bit. In sleep the regulator and monitors are off, but the register write interface still works.

Leaving sleep is driven by a wake pin, which arrives as an already-digitized comparator level. The pin is first filtered by a qualification delay counted in millisecond ticks. The wake action is edge-triggered on the filtered level, with a programmable polarity. A wake-status flag follows the filtered level at that same polarity.

The block also holds the small set of control bits that govern these modes:
- the sleep bit;
- the wake polarity and wake-disable bits;
- a self-clearing forced-reset command;
- the analog-select field and four user flags, which must survive sleep.

Software writes these bits through a simple write port.

Top module: `wake_sleep_ctrl`

## Requirements
- R1: After reset, and while in power-down, `pwr_state` is 0, all enables and the wake status are 0, and every register field reads 0. Writes issued in power-down are ignored. State codes are: 0 power-down, 1 main operating, 2 sleep.
- R2: From power-down the state becomes main one cycle after all `supply_good` bits are high. If any `supply_good` bit is low at a clock edge, the state is power-down after that edge, whatever the previous state.
- R3: Register map:
  - Address 0, bit 0 holds the sleep bit. Writing it to 1 in main sets `sleep_bit` after that edge, and the state becomes sleep one edge later.
  - Writing it to 0 while in sleep returns the block to main with the same two-edge timing.
- R4: `reg_en` and `mon_en` are 1 only in main. `bus_en` is 1 in main and in sleep.
- R5: The filtered wake level takes the value of `wake_in` only after `wake_in` has differed from it on QUAL_MS consecutive `ms_tick` pulses. If `wake_in` returns to the filtered level first, the count restarts from zero.
- R6: Address 1 holds the polarity in bit 0 (1 = rising edge, 0 = falling edge). `wake_status` is 1 when the filtered level equals that bit, and outside power-down.
- R7: In sleep, a filtered transition onto the active level clears `sleep_bit` after that edge, and the state returns to main one edge later. The status going inactive while in main never causes sleep.
- R8: Address 1, bit 1 is wake-disable. While it is 1, filtered transitions do not clear the sleep bit.
- R9: If the filtered level is already active when sleep is entered, the block stays in sleep until a new transition onto the active level occurs.
- R10: Address 2 holds the analog select in bits 3:0 and the user flags in bits 7:4. These fields, and the address-1 bits, keep their values through entry to and exit from sleep.
- R11: A write to address 1 with bit 7 set, outside power-down, has three effects:
  - all register fields are cleared after that edge;
  - the state is power-down for one cycle;
  - the state then returns to main if the supplies are good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_good | input | NUM_SUPPLIES | One per monitored supply, 1 = above its threshold |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wake_in | input | 1 | Digitized wake-pin comparator level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| pwr_state | output | 2 | 0 power-down, 1 main, 2 sleep |
| reg_en | output | 1 | Regulator enable |
| mon_en | output | 1 | Cell and temperature monitor enable |
| bus_en | output | 1 | Register interface active |
| wake_status | output | 1 | Filtered wake level at the selected polarity |
| sleep_bit | output | 1 | Software sleep request bit |
| wake_pol | output | 1 | Wake polarity bit |
| wake_dis | output | 1 | Wake-disable bit |
| ana_sel | output | 4 | Analog select field |
| user_flags | output | 4 | General-purpose flags |

## Verification
A wrong filtered level or a mis-counted qualification shows first at `wake_status`. It appears one cycle after the tick that should, or should not, have completed the delay, and the state change follows two edges later. A state register that disagrees with the sleep bit or the supplies shows directly on `pwr_state` and on the three enables in the following cycle. A lost or wrongly cleared register field shows at once on the field outputs, because they are exposed continuously. The bench therefore compares every output against its model on every cycle. This catches a divergence in the cycle where it first becomes visible.

// File: rtl/pwr_pkg.sv
// Shared types and register addresses for the wake-sleep power state controller.
package pwr_pkg;

    typedef enum logic [1:0] {
        ST_PD    = 2'd0,
        ST_MAIN  = 2'd1,
        ST_SLEEP = 2'd2
    } pwr_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_SEL  = 2'd2;

endpackage

// File: rtl/wake_qualifier.sv
// Wake-pin qualifier.
// Filters the digitized wake level with a delay counted in millisecond ticks.
// The filtered level adopts the pin value only after the pin has differed on
// QUAL_MS consecutive ticks; a return to the filtered level restarts the count.
// While hold is high, the filtered level tracks the pin directly and no change
// pulse is produced.
// Assumes wake_in is already synchronous to clk.
module wake_qualifier #(
    parameter int QUAL_MS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ms_tick,
    input  logic wake_in,
    output logic qual_level,
    output logic qual_chg
);
    localparam int CNT_W = $clog2(QUAL_MS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_MS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks while the pin differs; adopt the pin level when the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_level <= 1'b0;
            cnt_q      <= '0;
            qual_chg   <= 1'b0;
        end else if (hold) begin
            qual_level <= wake_in;
            cnt_q      <= '0;
            qual_chg   <= 1'b0;
        end else if (wake_in == qual_level) begin
            cnt_q    <= '0;
            qual_chg <= 1'b0;
        end else if (ms_tick) begin
            if (cnt_q == CNT_LAST) begin
                qual_level <= wake_in;
                cnt_q      <= '0;
                qual_chg   <= 1'b1;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
                qual_chg <= 1'b0;
            end
        end else begin
            qual_chg <= 1'b0;
        end
    end

    // R5: a filtered change outside hold always copies the previous pin value
    a_r5_follow_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(qual_level) && !$past(hold)) |-> (qual_level == $past(wake_in)));

    // R5: a filtered change outside hold is only ever completed by a tick
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(qual_level) && !$past(hold)) |-> $past(ms_tick));

endmodule

// File: rtl/pwr_state_fsm.sv
// Power-mode state machine: power-down, main operating and sleep.
// Supply loss or a forced reset takes priority from any state.
// Main and sleep follow the sleep bit held in the register block.
// Assumes force_rst is a single-cycle pulse.
module pwr_state_fsm #(
    parameter int NUM_SUPPLIES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SUPPLIES-1:0] supply_good,
    input  logic                    force_rst,
    input  logic                    sleep_bit,
    output pwr_pkg::pwr_state_t     state
);
    import pwr_pkg::*;

    logic       all_good;
    pwr_state_t state_nx;

    assign all_good = &supply_good;

    // Next-state selection with supply loss and forced reset first.
    always_comb begin
        state_nx = state;
        if (!all_good || force_rst) begin
            state_nx = ST_PD;
        end else begin
            case (state)
                ST_PD:    state_nx = ST_MAIN;
                ST_MAIN:  state_nx = sleep_bit ? ST_SLEEP : ST_MAIN;
                ST_SLEEP: state_nx = sleep_bit ? ST_SLEEP : ST_MAIN;
                default:  state_nx = ST_PD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PD;
        else        state <= state_nx;
    end

    // R2: losing any supply forces power-down at the next edge
    a_r2_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !(&supply_good) |=> (state == ST_PD));

    // R2: power-down with good supplies moves to main at the next edge
    a_r2_power_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PD && (&supply_good)) |=> (state == ST_MAIN));

    // R3: a set sleep bit in main leads to sleep at the next edge
    a_r3_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAIN && sleep_bit && (&supply_good) && !force_rst) |=> (state == ST_SLEEP));

    // R11: a forced reset always passes through power-down
    a_r11_force_pd: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst |=> (state == ST_PD));

endmodule

// File: rtl/pwr_cfg_regs.sv
// Control and configuration register block.
// Holds the sleep bit, the wake polarity and disable bits, the analog select
// field and the user flags. Every field is cleared while clear is high
// (power-down or forced reset). A wake clear overrides a same-cycle write to
// the sleep bit.
// Assumes wr_ok is already gated to states outside power-down.
module pwr_cfg_regs #(
    parameter int SEL_W  = 4,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_ok,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wake_clr,
    output logic              sleep_q,
    output logic              pol_q,
    output logic              dis_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [FLAG_W-1:0] flag_q
);
    import pwr_pkg::*;

    localparam int FLAG_LO = SEL_W;

    // Register writes, hardware clear of the sleep bit, and clear on power-down or forced reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sleep_q <= 1'b0;
            pol_q   <= 1'b0;
            dis_q   <= 1'b0;
            sel_q   <= '0;
            flag_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (wr_addr)
                    ADDR_CTRL: sleep_q <= wr_data[0];
                    ADDR_CFG: begin
                        pol_q <= wr_data[0];
                        dis_q <= wr_data[1];
                    end
                    ADDR_SEL: begin
                        sel_q  <= wr_data[SEL_W-1:0];
                        flag_q <= wr_data[FLAG_LO +: FLAG_W];
                    end
                    default: ;
                endcase
            end
            if (wake_clr) sleep_q <= 1'b0;
        end
    end

    // R1: fields are zero while power-down persists
    a_r1_zero_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (!sleep_q && !pol_q && !dis_q && sel_q == '0 && flag_q == '0));

    // R7: a wake event always leaves the sleep bit cleared
    a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr |=> !sleep_q);

    // R10: without a write or clear, the select field and flags keep their values
    a_r10_retained: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !clear) |=> ($stable(sel_q) && $stable(flag_q) && $stable(pol_q) && $stable(dis_q)));

endmodule

// File: rtl/wake_sleep_ctrl.sv
// Top level of the wake-sleep power state controller.
// Joins the wake qualifier, the state machine and the register block.
// Derives the wake event from a filtered transition onto the active polarity,
// and drives the regulator, monitor and interface enables.
// Assumes ms_tick is a single-cycle pulse and wake_in is synchronous to clk.
module wake_sleep_ctrl #(
    parameter int NUM_SUPPLIES = 4,
    parameter int QUAL_MS      = 40,
    parameter int SEL_W        = 4,
    parameter int FLAG_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SUPPLIES-1:0] supply_good,
    input  logic                    ms_tick,
    input  logic                    wake_in,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [7:0]              wr_data,
    output logic [1:0]              pwr_state,
    output logic                    reg_en,
    output logic                    mon_en,
    output logic                    bus_en,
    output logic                    wake_status,
    output logic                    sleep_bit,
    output logic                    wake_pol,
    output logic                    wake_dis,
    output logic [SEL_W-1:0]        ana_sel,
    output logic [FLAG_W-1:0]       user_flags
);
    import pwr_pkg::*;

    localparam int FORCE_BIT = 7;

    pwr_state_t state;
    logic       in_pd;
    logic       wr_ok;
    logic       force_rst;
    logic       qual_level;
    logic       qual_chg;
    logic       active_edge;
    logic       wake_clr;

    // Interface gating and command decode.
    always_comb begin
        in_pd     = (state == ST_PD);
        wr_ok     = wr_en && !in_pd;
        force_rst = wr_ok && (wr_addr == ADDR_CFG) && wr_data[FORCE_BIT];
    end

    wake_qualifier #(.QUAL_MS(QUAL_MS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (in_pd),
        .ms_tick    (ms_tick),
        .wake_in    (wake_in),
        .qual_level (qual_level),
        .qual_chg   (qual_chg)
    );

    pwr_state_fsm #(.NUM_SUPPLIES(NUM_SUPPLIES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .force_rst   (force_rst),
        .sleep_bit   (sleep_bit),
        .state       (state)
    );

    pwr_cfg_regs #(.SEL_W(SEL_W), .FLAG_W(FLAG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (in_pd || force_rst),
        .wr_ok    (wr_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wake_clr (wake_clr),
        .sleep_q  (sleep_bit),
        .pol_q    (wake_pol),
        .dis_q    (wake_dis),
        .sel_q    (ana_sel),
        .flag_q   (user_flags)
    );

    // Wake event: a filtered transition onto the active level while asleep and enabled.
    always_comb begin
        active_edge = qual_chg && (qual_level == wake_pol);
        wake_clr    = (state == ST_SLEEP) && active_edge && !wake_dis;
    end

    // Output enables and status.
    always_comb begin
        pwr_state   = state;
        reg_en      = (state == ST_MAIN);
        mon_en      = (state == ST_MAIN);
        bus_en      = (state != ST_PD);
        wake_status = !in_pd && (qual_level == wake_pol);
    end

    // R8: with wake disabled, a filtered edge never clears the sleep bit
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_dis && sleep_bit && !wr_ok && (&supply_good)) |=> sleep_bit);

    // R9: sleep is left only by a write, a filtered transition, or supply loss
    a_r9_no_level_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !qual_chg && !wr_ok && (&supply_good)) |=> $stable(sleep_bit));

endmodule

// File: tb/test_wake_sleep_ctrl.sv
// Bench for wake_sleep_ctrl.
// A behavioural reference model is compared with every output on every clock,
// and directed checks cover each requirement.
module test_wake_sleep_ctrl;
    localparam int NS   = 4;
    localparam int QMS  = 40;
    localparam int TICK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] supply_good = '0;
    logic          ms_tick = 1'b0;
    logic          wake_in = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    pwr_state;
    logic          reg_en, mon_en, bus_en, wake_status, sleep_bit, wake_pol, wake_dis;
    logic [3:0]    ana_sel, user_flags;

    wake_sleep_ctrl #(.NUM_SUPPLIES(NS), .QUAL_MS(QMS)) i_wake_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .ms_tick(ms_tick),
        .wake_in(wake_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwr_state(pwr_state), .reg_en(reg_en), .mon_en(mon_en), .bus_en(bus_en),
        .wake_status(wake_status), .sleep_bit(sleep_bit), .wake_pol(wake_pol),
        .wake_dis(wake_dis), .ana_sel(ana_sel), .user_flags(user_flags)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Millisecond tick: one pulse every TICK cycles, driven on the falling edge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % TICK;
        ms_tick <= (tdiv == 0);
    end

    // Reference model state.
    int m_state = 0;
    int m_sleep = 0, m_pol = 0, m_dis = 0, m_sel = 0, m_uf = 0;
    int m_qual = 0, m_cnt = 0, m_chg = 0;

    always @(posedge clk) begin
        int pd, wok, frc, allg, wclr, ns;
        int n_sleep, n_pol, n_dis, n_sel, n_uf, n_qual, n_cnt, n_chg;
        started = 1;
        if (!rst_n) begin
            m_state = 0; m_sleep = 0; m_pol = 0; m_dis = 0; m_sel = 0; m_uf = 0;
            m_qual = 0; m_cnt = 0; m_chg = 0;
        end else begin
            pd   = (m_state == 0);
            wok  = wr_en && !pd;
            frc  = wok && wr_addr == 1 && wr_data[7];
            allg = (supply_good == {NS{1'b1}});
            wclr = (m_state == 2) && m_chg && (m_qual == m_pol) && !m_dis;
            if (!allg || frc) ns = 0;
            else if (m_state == 0) ns = 1;
            else ns = m_sleep ? 2 : 1;
            n_sleep = m_sleep; n_pol = m_pol; n_dis = m_dis; n_sel = m_sel; n_uf = m_uf;
            if (pd || frc) begin
                n_sleep = 0; n_pol = 0; n_dis = 0; n_sel = 0; n_uf = 0;
            end else begin
                if (wok && wr_addr == 0) n_sleep = wr_data[0];
                if (wok && wr_addr == 1) begin n_pol = wr_data[0]; n_dis = wr_data[1]; end
                if (wok && wr_addr == 2) begin n_sel = wr_data[3:0]; n_uf = wr_data[7:4]; end
                if (wclr) n_sleep = 0;
            end
            n_qual = m_qual; n_cnt = m_cnt; n_chg = 0;
            if (pd) begin
                n_qual = wake_in; n_cnt = 0;
            end else if (wake_in == m_qual) begin
                n_cnt = 0;
            end else if (ms_tick) begin
                if (m_cnt == QMS - 1) begin n_qual = wake_in; n_cnt = 0; n_chg = 1; end
                else n_cnt = m_cnt + 1;
            end
            m_state = ns; m_sleep = n_sleep; m_pol = n_pol; m_dis = n_dis;
            m_sel = n_sel; m_uf = n_uf; m_qual = n_qual; m_cnt = n_cnt; m_chg = n_chg;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 state", pwr_state, m_state);
            chk("R4 reg_en", reg_en, m_state == 1);
            chk("R4 mon_en", mon_en, m_state == 1);
            chk("R4 bus_en", bus_en, m_state != 0);
            chk("R6 wake_status", wake_status, (m_state != 0) && (m_qual == m_pol));
            chk("R3 sleep_bit", sleep_bit, m_sleep);
            chk("R10 wake_pol", wake_pol, m_pol);
            chk("R8 wake_dis", wake_dis, m_dis);
            chk("R10 ana_sel", ana_sel, m_sel);
            chk("R10 user_flags", user_flags, m_uf);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ms(input int n);
        cyc(n * TICK + 2);
    endtask

    initial begin
        cyc(3);
        chk("R1 reset state", pwr_state, 0);
        chk("R1 reset reg_en", reg_en, 0);
        chk("R1 reset status", wake_status, 0);
        rst_n = 1'b1;
        wr(2'd2, 8'hA5);
        chk("R1 write ignored in power-down", ana_sel, 0);
        supply_good = '1;
        cyc(1);
        chk("R2 main after supplies good", pwr_state, 1);
        wr(2'd2, 8'h93);
        chk("R10 select written", ana_sel, 3);
        wr(2'd0, 8'h01);
        cyc(1);
        chk("R3 sleep entered", pwr_state, 2);
        chk("R4 regulator off in sleep", reg_en, 0);
        chk("R4 interface on in sleep", bus_en, 1);
        wake_in = 1'b0;
        wait_ms(10);
        wake_in = 1'b1;
        wait_ms(QMS - 5);
        chk("R5 short pulse filtered", wake_status, 0);
        chk("R5 still asleep", pwr_state, 2);
        wake_in = 1'b0;
        wait_ms(QMS + 2);
        chk("R7 falling edge wakes", pwr_state, 1);
        chk("R6 status active low", wake_status, 1);
        chk("R10 select kept", ana_sel, 3);
        chk("R10 flags kept", user_flags, 9);
        wake_in = 1'b1;
        wait_ms(QMS + 2);
        chk("R7 inactive status keeps main", pwr_state, 1);
        wr(2'd1, 8'h01);
        chk("R6 polarity high status", wake_status, 1);
        wr(2'd0, 8'h01);
        wait_ms(5);
        chk("R9 active level no wake", pwr_state, 2);
        wake_in = 1'b0;
        wait_ms(QMS + 2);
        wake_in = 1'b1;
        wait_ms(QMS + 2);
        chk("R7 rising edge wakes", pwr_state, 1);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        wake_in = 1'b0;
        wait_ms(QMS + 2);
        wake_in = 1'b1;
        wait_ms(QMS + 2);
        chk("R8 disabled stays asleep", pwr_state, 2);
        wr(2'd0, 8'h00);
        cyc(1);
        chk("R3 write zero returns to main", pwr_state, 1);
        supply_good[2] = 1'b0;
        cyc(2);
        chk("R2 supply loss power-down", pwr_state, 0);
        chk("R1 registers cleared", wake_dis, 0);
        supply_good = '1;
        cyc(2);
        chk("R2 recovered", pwr_state, 1);
        wr(2'd2, 8'h5C);
        wr(2'd1, 8'h81);
        chk("R11 forced power-down", pwr_state, 0);
        chk("R11 fields cleared", ana_sel, 0);
        cyc(1);
        chk("R11 back to main", pwr_state, 1);
        cyc(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule